// File: doc/BRIEF.md
# Configurable Port with Chip-Select Logic

This block is an eight-pin bidirectional port that sits on a microcontroller bus. Software picks a role for each pin on its own. A pin can be general-purpose I/O, where a direction bit and a data bit control the pad. A pin can instead be a chip-select output, where its level is a sum of programmable product terms. The product terms read the latched address and a few bus control lines, so a chip select can decode an address window or implement any other logic those literals can express. Each pin can also be switched from push-pull to open-drain drive.

The bus side is a byte-wide register interface. Writes take effect on the clock edge where `bus_we` is sampled high. Read data is registered, so it appears one cycle after the address. The pad side carries a registered output level, a registered output enable and a raw input for each pin. The raw inputs pass through two synchronizing flops before software can read them. The product-term array is sized by parameters. By default, pins 0 to 3 each own four terms and pins 4 to 7 each own two, which gives 24 terms in all.

Top module: `cfg_port_cs`

## Requirements
- R1: Reset leaves every pin an input with output enable low. The direction, data, mode and drain-select registers and every product-term word read back as zero, so all terms are disabled.
- R2: Offset 1 holds the direction bits (1 = drive). For a pin in I/O mode with push-pull drive, `pad_oe` follows its direction bit on the clock edge after the write has been registered.
- R3: Offset 2 holds the data bits. A push-pull I/O pin puts its data bit on `pad_out`, one edge after the write.
- R4: Offset 0 reads the pad levels after two synchronizing flops. A change on `pad_in` shows in read data on the third rising edge. Writes to offset 0 change no register.
- R5: Offset 4 selects open-drain per pin (1 = open-drain). Such a pin always has `pad_out` = 0 and enables its driver only when the level it would output is 0. This applies in both I/O mode and chip-select mode.
- R6: Offset 3 holds the mode bits (1 = chip-select). A chip-select pin drives its chip-select value with push-pull enable high, whatever its direction and data bits hold.
- R7: Each product term is a 32-bit word. Term t occupies byte offsets 8+4t (bits 7:0) up to 11+4t (bits 31:24). The literal vector is {`bus_ctl`, `lat_addr`}, with `lat_addr` bit 0 as literal 0. Literal i is selected by word bits [2i+1:2i]: 00 = ignore, 01 = true form, 10 = complement, 11 = the term is always false. Bit 31 enables the term.
- R8: Terms are numbered by pin. Pins 0 to 3 own terms 4n to 4n+3. Pin n of 4 to 7 owns terms 16+2(n-4) and 17+2(n-4). Chip-select n is the OR of its own terms only.
- R9: An enabled term whose literals are all ignored evaluates to 1. A disabled term evaluates to 0, whatever its literal fields hold. A chip-select pin with no enabled term outputs 0.
- R10: A change on `lat_addr` or `bus_ctl` reaches a chip-select pad on the first rising edge after it.
- R11: Read data registers the addressed byte on each rising edge. Offsets 5 to 7, and offsets past the last term word, read as zero. Term words read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| lat_addr | input | 8 | Latched address, literals 0 to 7 |
| bus_ctl | input | 3 | Bus control lines, literals 8 to 10 |
| pad_in | input | 8 | Raw level sampled at each pad |
| pad_out | output | 8 | Registered pad output level |
| pad_oe | output | 8 | Registered pad output enable |

## Verification
Most configuration faults in this block become visible at the pads within one edge. A wrong mode, drain or direction bit flips `pad_oe`. A term mapped to the wrong pin, or a literal decoded in the wrong polarity, gives a wrong chip-select level one edge after the address that exposes it. A fault in the synchronizer or in read-data timing can be seen only by sampling read data on the exact edge, so the pin-register latency is checked both one edge early and on time. Faults in term storage show up either through readback or through a chip-select that stays stuck.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef enum logic [1:0] {
    LIT_ANY   = 2'b00,
    LIT_TRUE  = 2'b01,
    LIT_INV   = 2'b10,
    LIT_NEVER = 2'b11
  } lit_sel_e;

  localparam int OFS_PIN    = 0;
  localparam int OFS_DIR    = 1;
  localparam int OFS_DATA   = 2;
  localparam int OFS_MODE   = 3;
  localparam int OFS_ODRAIN = 4;
  localparam int OFS_TERM   = 8;

  function automatic int pin_term_count(int pin, int wide_pins, int wide_terms, int narrow_terms);
    return (pin < wide_pins) ? wide_terms : narrow_terms;
  endfunction

  function automatic int pin_term_base(int pin, int wide_pins, int wide_terms, int narrow_terms);
    return (pin < wide_pins) ? pin * wide_terms
                             : wide_pins * wide_terms + (pin - wide_pins) * narrow_terms;
  endfunction

endpackage

// File: rtl/cfgport_regs.sv
module cfgport_regs
  import cfgport_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int DW     = 8,
  parameter int AW     = 7,
  parameter int NTERMS = 24,
  parameter int NLIT   = 11,
  parameter int TW     = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  input  logic [PINS-1:0]        pin_sync,
  output logic [DW-1:0]          bus_rdata,
  output logic [PINS-1:0]        dir_q,
  output logic [PINS-1:0]        data_q,
  output logic [PINS-1:0]        mode_q,
  output logic [PINS-1:0]        od_q,
  output logic [NTERMS*2*NLIT-1:0] term_sel,
  output logic [NTERMS-1:0]      term_en
);

  localparam int TB     = TW / DW;
  localparam int LANE_W = $clog2(TB);
  localparam int TIDX_W = $clog2(NTERMS);
  localparam int SW     = 2 * NLIT;

  localparam logic [AW-1:0] A_PIN  = AW'(OFS_PIN);
  localparam logic [AW-1:0] A_DIR  = AW'(OFS_DIR);
  localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
  localparam logic [AW-1:0] A_MODE = AW'(OFS_MODE);
  localparam logic [AW-1:0] A_OD   = AW'(OFS_ODRAIN);
  localparam logic [AW-1:0] A_TERM = AW'(OFS_TERM);

  logic [TW-1:0]     term_mem [NTERMS];
  logic [AW-1:0]     rel;
  logic [TIDX_W-1:0] tidx;
  logic [LANE_W-1:0] lane;
  logic              term_hit;
  logic [DW-1:0]     rd_next;

  assign rel      = bus_addr - A_TERM;
  assign tidx     = rel[LANE_W +: TIDX_W];
  assign lane     = rel[LANE_W-1:0];
  assign term_hit = (bus_addr >= A_TERM) && (int'(rel >> LANE_W) < NTERMS);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
      mode_q <= '0;
      od_q   <= '0;
      for (int t = 0; t < NTERMS; t++) term_mem[t] <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_DIR)       dir_q  <= bus_wdata[PINS-1:0];
      else if (bus_addr == A_DATA) data_q <= bus_wdata[PINS-1:0];
      else if (bus_addr == A_MODE) mode_q <= bus_wdata[PINS-1:0];
      else if (bus_addr == A_OD)   od_q   <= bus_wdata[PINS-1:0];
      else if (term_hit)           term_mem[tidx][lane*DW +: DW] <= bus_wdata;
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == A_PIN)       rd_next[PINS-1:0] = pin_sync;
    else if (bus_addr == A_DIR)  rd_next[PINS-1:0] = dir_q;
    else if (bus_addr == A_DATA) rd_next[PINS-1:0] = data_q;
    else if (bus_addr == A_MODE) rd_next[PINS-1:0] = mode_q;
    else if (bus_addr == A_OD)   rd_next[PINS-1:0] = od_q;
    else if (term_hit)           rd_next = term_mem[tidx][lane*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  for (genvar t = 0; t < NTERMS; t++) begin : g_flat
    assign term_sel[t*SW +: SW] = term_mem[t][SW-1:0];
    assign term_en[t]           = term_mem[t][TW-1];
  end

  AST_RESET_CLEARS_CFG: assert property (@(posedge clk)
    rst |=> (dir_q == '0 && data_q == '0 && mode_q == '0 && od_q == '0 && term_en == '0)); // R1

  AST_PIN_REG_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_PIN) |=> ($stable(dir_q) && $stable(data_q) && $stable(mode_q) && $stable(od_q))); // R4

  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr > A_OD && bus_addr < A_TERM) |=> (bus_rdata == '0)); // R11

endmodule

// File: rtl/cfgport_pterm.sv
module cfgport_pterm
  import cfgport_pkg::*;
#(
  parameter int NLIT = 11
) (
  input  logic [NLIT-1:0]   lits,
  input  logic [2*NLIT-1:0] sel,
  input  logic              enable,
  output logic              match
);

  always_comb begin
    match = enable;
    for (int i = 0; i < NLIT; i++) begin
      case (lit_sel_e'(sel[2*i +: 2]))
        LIT_ANY:   ;
        LIT_TRUE:  match = match & lits[i];
        LIT_INV:   match = match & ~lits[i];
        LIT_NEVER: match = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cfgport_csarray.sv
module cfgport_csarray
  import cfgport_pkg::*;
#(
  parameter int PINS         = 8,
  parameter int WIDE_PINS    = 4,
  parameter int WIDE_TERMS   = 4,
  parameter int NARROW_TERMS = 2,
  parameter int NTERMS       = 24,
  parameter int NLIT         = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NLIT-1:0]          lits,
  input  logic [NTERMS*2*NLIT-1:0] term_sel,
  input  logic [NTERMS-1:0]        term_en,
  output logic [PINS-1:0]          cs
);

  localparam int SW = 2 * NLIT;

  logic [NTERMS-1:0] hit;

  for (genvar t = 0; t < NTERMS; t++) begin : g_term
    cfgport_pterm #(.NLIT(NLIT)) u_term (
      .lits   (lits),
      .sel    (term_sel[t*SW +: SW]),
      .enable (term_en[t]),
      .match  (hit[t])
    );
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    localparam int BASE = pin_term_base(p, WIDE_PINS, WIDE_TERMS, NARROW_TERMS);
    localparam int CNT  = pin_term_count(p, WIDE_PINS, WIDE_TERMS, NARROW_TERMS);
    assign cs[p] = |hit[BASE +: CNT];

    AST_IDLE_PIN_LOW: assert property (@(posedge clk) disable iff (rst)
      (term_en[BASE +: CNT] == '0) |-> !cs[p]); // R9
  end

endmodule

// File: rtl/cfgport_padctl.sv
module cfgport_padctl #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pad_in,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] data_q,
  input  logic [PINS-1:0] mode_q,
  input  logic [PINS-1:0] od_q,
  input  logic [PINS-1:0] cs,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pin_sync
);

  logic [PINS-1:0] sync_a, sync_b;
  logic [PINS-1:0] lvl, drive, nxt_out, nxt_oe;
  logic [1:0]      warm;

  always_comb begin
    lvl     = (mode_q & cs) | (~mode_q & data_q);
    drive   = mode_q | dir_q;
    nxt_out = lvl & ~od_q;
    nxt_oe  = (od_q & drive & ~lvl) | (~od_q & drive);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      sync_a  <= '0;
      sync_b  <= '0;
      warm    <= '0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
      sync_a  <= pad_in;
      sync_b  <= sync_a;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  assign pin_sync = sync_b;

  AST_SYNC_TWO_FLOP: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (pin_sync == $past(pad_in, 2))); // R4

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & pad_out & $past(od_q)) == '0)); // R5

  AST_CS_PIN_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (($past(mode_q) & ~$past(od_q) & ~pad_oe) == '0)); // R6

  AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (($past(~mode_q & ~dir_q) & pad_oe) == '0)); // R2

endmodule

// File: rtl/cfg_port_cs.sv
module cfg_port_cs #(
  parameter int PINS         = 8,
  parameter int DW           = 8,
  parameter int AW           = 7,
  parameter int ADDR_W       = 8,
  parameter int CTRL_W       = 3,
  parameter int WIDE_PINS    = 4,
  parameter int WIDE_TERMS   = 4,
  parameter int NARROW_TERMS = 2,
  parameter int TW           = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [CTRL_W-1:0] bus_ctl,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);

  localparam int NLIT   = ADDR_W + CTRL_W;
  localparam int NTERMS = WIDE_PINS * WIDE_TERMS + (PINS - WIDE_PINS) * NARROW_TERMS;

  logic [PINS-1:0]          dir_q, data_q, mode_q, od_q, cs, pin_sync;
  logic [NTERMS*2*NLIT-1:0] term_sel;
  logic [NTERMS-1:0]        term_en;
  logic [NLIT-1:0]          lits;

  assign lits = {bus_ctl, lat_addr};

  cfgport_regs #(
    .PINS(PINS), .DW(DW), .AW(AW), .NTERMS(NTERMS), .NLIT(NLIT), .TW(TW)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_sync  (pin_sync),
    .bus_rdata (bus_rdata),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .mode_q    (mode_q),
    .od_q      (od_q),
    .term_sel  (term_sel),
    .term_en   (term_en)
  );

  cfgport_csarray #(
    .PINS(PINS), .WIDE_PINS(WIDE_PINS), .WIDE_TERMS(WIDE_TERMS),
    .NARROW_TERMS(NARROW_TERMS), .NTERMS(NTERMS), .NLIT(NLIT)
  ) u_cs (
    .clk      (clk),
    .rst      (rst),
    .lits     (lits),
    .term_sel (term_sel),
    .term_en  (term_en),
    .cs       (cs)
  );

  cfgport_padctl #(.PINS(PINS)) u_pad (
    .clk      (clk),
    .rst      (rst),
    .pad_in   (pad_in),
    .dir_q    (dir_q),
    .data_q   (data_q),
    .mode_q   (mode_q),
    .od_q     (od_q),
    .cs       (cs),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pin_sync (pin_sync)
  );

endmodule

// File: tb/cfg_port_cs_test.sv
`timescale 1ns/1ps
module cfg_port_cs_test;
  localparam int AW = 7, ADDR_W = 8, CTRL_W = 3, NLIT = 11, NTERMS = 24;

  logic              clk = 1'b0, rst = 1'b1, bus_we = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [7:0]        bus_wdata = '0, bus_rdata;
  logic [ADDR_W-1:0] lat_addr = '0;
  logic [CTRL_W-1:0] bus_ctl = '0;
  logic [7:0]        pad_in = '0, pad_out, pad_oe;

  always #2.5 clk = ~clk;

  cfg_port_cs uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lat_addr(lat_addr),
    .bus_ctl(bus_ctl), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct {
    bit         is_rd;
    logic [7:0] e_a;
    logic [7:0] e_b;
    string      tag;
  } item_t;

  item_t sb[$];
  int    nq = 0, n_chk = 0, n_bad = 0;
  bit    done = 0;

  bit [7:0]  m_dir = '0, m_data = '0, m_mode = '0, m_od = '0;
  bit [31:0] m_term [NTERMS];

  function automatic bit term_val(bit [31:0] w, bit [NLIT-1:0] l);
    bit r = w[31];
    for (int i = 0; i < NLIT; i++) begin
      case (w[2*i +: 2])
        2'b01: if (!l[i]) r = 1'b0;
        2'b10: if (l[i]) r = 1'b0;
        2'b11: r = 1'b0;
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic bit [7:0] cs_model();
    bit [7:0] c = '0;
    bit [NLIT-1:0] l = {bus_ctl, lat_addr};
    for (int p = 0; p < 8; p++) begin
      int base = (p < 4) ? p * 4 : 16 + (p - 4) * 2;
      int cnt  = (p < 4) ? 4 : 2;
      for (int k = 0; k < cnt; k++) c[p] = c[p] | term_val(m_term[base + k], l);
    end
    return c;
  endfunction

  task automatic push_wait(item_t it);
    sb.push_back(it);
    nq++;
    wait (nq == 0);
  endtask

  task automatic chk_pads(string tag);
    item_t it;
    bit [7:0] c = cs_model();
    bit [7:0] o, e;
    for (int p = 0; p < 8; p++) begin
      bit lv = m_mode[p] ? c[p] : m_data[p];
      bit dr = m_mode[p] | m_dir[p];
      o[p] = m_od[p] ? 1'b0 : lv;
      e[p] = m_od[p] ? (dr & ~lv) : dr;
    end
    it.is_rd = 0; it.e_a = o; it.e_b = e; it.tag = tag;
    push_wait(it);
  endtask

  task automatic rd_chk(int a, bit [7:0] exp, string tag);
    item_t it;
    bus_addr = AW'(a);
    it.is_rd = 1; it.e_a = exp; it.e_b = '0; it.tag = tag;
    push_wait(it);
  endtask

  task automatic wr(int a, bit [7:0] d);
    case (a)
      1: m_dir  = d;
      2: m_data = d;
      3: m_mode = d;
      4: m_od   = d;
      default: if (a >= 8 && a < 8 + 4 * NTERMS) m_term[(a - 8) / 4][((a - 8) % 4) * 8 +: 8] = d;
    endcase
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_term(int t, bit [31:0] w);
    for (int b = 0; b < 4; b++) wr(8 + 4 * t + b, w[8*b +: 8]);
  endtask

  task automatic set_lits(bit [7:0] a, bit [2:0] c);
    lat_addr = a; bus_ctl = c;
  endtask

  function automatic bit [31:0] mk_lit(int i, bit [1:0] code);
    bit [31:0] w = 32'h8000_0000;
    w[2*i +: 2] = code;
    return w;
  endfunction

  function automatic bit [31:0] mk_exact(bit [7:0] a);
    bit [31:0] w = 32'h8000_0000;
    for (int i = 0; i < 8; i++) w[2*i +: 2] = a[i] ? 2'b01 : 2'b10;
    return w;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // monitor: compares each expected item one rising edge after it was queued
  initial begin
    forever begin
      item_t it;
      wait (nq != 0);
      @(negedge clk);
      it = sb.pop_front();
      n_chk++;
      if (it.is_rd) begin
        if (bus_rdata !== it.e_a) begin
          n_bad++;
          $display("FAIL %s: rdata actual=%h expected=%h", it.tag, bus_rdata, it.e_a);
        end
      end else if (pad_out !== it.e_a || pad_oe !== it.e_b) begin
        n_bad++;
        $display("FAIL %s: actual out=%h oe=%h expected out=%h oe=%h",
                 it.tag, pad_out, pad_oe, it.e_a, it.e_b);
      end
      nq--;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    chk_pads("R1 pads after reset");
    rd_chk(1, 8'h00, "R1 dir reset");
    rd_chk(2, 8'h00, "R1 data reset");
    rd_chk(3, 8'h00, "R1 mode reset");
    rd_chk(4, 8'h00, "R1 drain reset");
    rd_chk(8 + 4 * 5 + 3, 8'h00, "R1 term enable byte reset");

    wr(2, 8'h5A); wr(1, 8'hFF);
    chk_pads("R2 R3 all outputs");
    wr(2, 8'hA5);
    chk_pads("R3 data change");
    wr(1, 8'h0F);
    chk_pads("R2 half inputs");

    pad_in = 8'h3C;
    repeat (2) @(negedge clk);
    rd_chk(0, 8'h3C, "R4 pin read");
    wr(0, 8'hFF);
    rd_chk(1, m_dir, "R4 pin write ignored dir");
    rd_chk(0, 8'h3C, "R4 pin write ignored pin");
    pad_in = 8'hC3;
    @(negedge clk);
    rd_chk(0, 8'h3C, "R4 sync not yet through");
    rd_chk(0, 8'hC3, "R4 sync third edge");

    wr(1, 8'hFF); wr(2, 8'hF0); wr(4, 8'hFF);
    chk_pads("R5 open-drain gpio");
    wr(4, 8'h00);
    chk_pads("R5 back to push-pull");

    wr(1, 8'h00); wr(2, 8'hFF);
    wr_term(0, mk_exact(8'hA5));
    wr_term(3, mk_lit(8, 2'b10));
    wr_term(4, mk_lit(10, 2'b01) | mk_lit(7, 2'b10));
    wr_term(15, 32'h8000_0000);
    wr_term(16, 32'h8000_0000);
    wr_term(19, 32'h0000_0000);
    wr_term(21, 32'h8000_0003);
    wr_term(23, mk_lit(7, 2'b01));
    wr(3, 8'hFF);
    chk_pads("R6 R8 R9 chip-select mode, dir/data ignored");

    set_lits(8'hA5, 3'b001);
    chk_pads("R10 R7 exact address match");
    set_lits(8'hA4, 3'b001);
    chk_pads("R10 R7 address miss");
    set_lits(8'hA4, 3'b110);
    chk_pads("R7 R8 complement control literal");
    set_lits(8'h24, 3'b100);
    chk_pads("R7 R8 mixed-polarity term on pin 1");

    wr(4, 8'h30);
    chk_pads("R5 open-drain chip-select pins");
    wr(3, 8'h0F);
    chk_pads("R6 R2 upper pins back to io");

    rd_chk(8, m_term[0][7:0], "R11 term byte readback");
    rd_chk(8 + 4 * 23 + 1, m_term[23][15:8], "R11 last term readback");
    rd_chk(3, 8'h0F, "R11 mode readback");
    rd_chk(5, 8'h00, "R11 gap offset");
    rd_chk(8 + 4 * NTERMS, 8'h00, "R11 past last term");
    rd_chk(127, 8'h00, "R11 top offset");

    done = 1;
    summary();
    $finish;
  end

endmodule